// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block takes sixteen interrupt levels, ranked 0 (lowest) to 15 (highest), and turns them into one request to the CPU. Each request has the 16-bit word address of its vector-table slot. The slot address depends only on the winning level. Level 15 is the reset request and is never gated. Level 14 merges two sources: a non-maskable event, and an oscillator-fault event that only its own enable can block. Levels 0 to 13 are fully maskable: each needs its own enable and the global interrupt enable.

Peripherals present their request lines already combined. If a level has several source flags, their OR drives one line. Unused levels are tied low. The controller picks the winner combinationally. It registers the strobe, level and vector address on the next clock edge. It holds the global interrupt enable bit, which software sets and clears with two pulse inputs. When the CPU acknowledges an active request, the controller drops the global enable. Maskable requests then stay blocked until software enables interrupts again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While rst_n is low and right after it is released, req_o is 0, gie_o is 0, level_o is 0 and vec_addr_o is 0xFFE0.
- R2: Whenever a level p is presented, vec_addr_o equals 0xFFE0 + 2·p and level_o equals p. Level 15 gives 0xFFFE, level 14 gives 0xFFFC and level 0 gives 0xFFE0.
- R3: When several levels qualify in one cycle, the highest level wins. req_o, level_o and vec_addr_o show that result one clock edge after the inputs are sampled.
- R4: rst_req_i gives level 15 at the next edge, whatever the enables and any other request.
- R5: nmi_req_i gives level 14 at the next edge when no reset request is present, even with gie_o low. It has no enable of its own.
- R6: ofault_req_i gives level 14 only when ofault_en_i is 1. A low gie_o does not block it.
- R7: A line irq_req_i[p] (levels 0 to 13, bit p gives level p) qualifies only when irq_en_i[p] is 1 and the global enable is 1.
- R8: gie_set_i sets gie_o at the next edge and gie_clr_i clears it. If both are high, the clear wins.
- R9: When ack_i is high while req_o is high, gie_o is 0 after that edge, even if gie_set_i is also high. In that same cycle, maskable lines are already treated as disabled.
- R10: ack_i while req_o is low has no effect on gie_o or on the outputs.
- R11: In a cycle with no qualified request, req_o drops at the next edge, and level_o and vec_addr_o keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Level-15 reset request (power-up, pin, watchdog) |
| nmi_req_i | input | 1 | Non-maskable request, level 14 |
| ofault_req_i | input | 1 | Oscillator-fault request, level 14 |
| ofault_en_i | input | 1 | Enable for the oscillator-fault request |
| irq_req_i | input | 14 | Maskable request lines, bit p is level p |
| irq_en_i | input | 14 | Per-line enables for irq_req_i |
| gie_set_i | input | 1 | Pulse: set the global interrupt enable |
| gie_clr_i | input | 1 | Pulse: clear the global interrupt enable |
| ack_i | input | 1 | CPU acknowledge of the current request |
| req_o | output | 1 | Registered request strobe to the CPU |
| level_o | output | 4 | Registered winning level |
| vec_addr_o | output | 16 | Registered vector-table word address |
| gie_o | output | 1 | Global interrupt enable state |

## Verification
The bench targets the ack cycle. A design that used the registered enable there would let a nested maskable request through one cycle after the acknowledge. The bench also raises NMI and the oscillator fault with the global enable off. A design with the wrong masking class would either drop these requests or take a disabled oscillator fault. It checks that a reset request overrides every other level, and that a simultaneous set and clear leaves the enable at 0. In idle cycles it checks that the vector address is held; a design that reloaded it would show 0xFFE0 or a stale level. Random traffic with mixed enables, acknowledges and set and clear pulses runs against the bench's own model.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  // Masking classes applied per level by the qualifier.
  typedef enum logic [1:0] {
    MASK_NEVER    = 2'd0,  // reset level: always taken
    MASK_EN_ONLY  = 2'd1,  // level shared by NMI and oscillator fault
    MASK_FULL     = 2'd2   // ordinary lines: own enable and global enable
  } mask_class_e;

  // Class of a given level for a controller with n_levels levels.
  function automatic mask_class_e class_of(input int lvl, input int n_levels);
    if (lvl == n_levels - 1)      return MASK_NEVER;
    else if (lvl == n_levels - 2) return MASK_EN_ONLY;
    else                          return MASK_FULL;
  endfunction

endpackage

// File: rtl/ivc_qualify.sv
module ivc_qualify
  import ivc_pkg::*;
#(
  parameter int LEVELS = 16,
  localparam int MASK_N = LEVELS - 2
) (
  input  logic              rst_req_i,
  input  logic              nmi_req_i,
  input  logic              ofault_req_i,
  input  logic              ofault_en_i,
  input  logic [MASK_N-1:0] mreq_i,
  input  logic [MASK_N-1:0] men_i,
  input  logic              gie_eff_i,
  output logic [LEVELS-1:0] qual_o
);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    if (class_of(g, LEVELS) == MASK_NEVER) begin : g_never
      assign qual_o[g] = rst_req_i;
    end else if (class_of(g, LEVELS) == MASK_EN_ONLY) begin : g_en_only
      assign qual_o[g] = nmi_req_i | (ofault_req_i & ofault_en_i);
    end else begin : g_full
      assign qual_o[g] = mreq_i[g] & men_i[g] & gie_eff_i;
    end
  end

endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int LEVELS = 16,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] qual_i,
  output logic              any_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [LEVELS-1:0] grant_o
);

  always_comb begin
    any_o = 1'b0;
    lvl_o = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (qual_i[i]) begin
        any_o = 1'b1;
        lvl_o = LVL_W'(i);
      end
    end
    grant_o = any_o ? (LEVELS'(1) << lvl_o) : '0;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));                                                  // R3
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~qual_i) == '0);                                          // R3
  AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((qual_i >> lvl_o) >> 1) == '0);                           // R3

endmodule

// File: rtl/ivc_gie_ctrl.sv
module ivc_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic gie_o,
  output logic gie_eff_o
);

  logic gie_q, gie_d, gie_ce;

  always_comb begin
    gie_ce = take_i | clr_i | set_i;
    if (take_i)     gie_d = 1'b0;
    else if (clr_i) gie_d = 1'b0;
    else            gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_ce) gie_q <= gie_d;
  end

  assign gie_o     = gie_q;
  assign gie_eff_o = gie_q & ~take_i;

  AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !gie_o);                                                  // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !gie_o);                                                   // R8
  AST_SET_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !take_i) |=> gie_o);                             // R8
  AST_GIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !take_i) |=> $stable(gie_o));                   // R10

endmodule

// File: rtl/ivc_vec_reg.sv
module ivc_vec_reg #(
  parameter int LEVELS = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic              req_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [ADDR_W-1:0] vec_o
);

  logic              req_q, req_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic              sel_ce;

  always_comb begin
    req_d  = any_i;
    sel_ce = any_i;
    lvl_d  = lvl_i;
    vec_d  = VEC_BASE + (ADDR_W'(lvl_i) << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= VEC_BASE;
    end else if (sel_ce) begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign req_o = req_q;
  assign lvl_o = lvl_q;
  assign vec_o = vec_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_i |=> (!req_o && $stable(lvl_o) && $stable(vec_o)));            // R11
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    any_i |=> (req_o && lvl_o == $past(lvl_i)));                         // R3

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int LEVELS = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int MASK_N = LEVELS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req_i,
  input  logic              nmi_req_i,
  input  logic              ofault_req_i,
  input  logic              ofault_en_i,
  input  logic [MASK_N-1:0] irq_req_i,
  input  logic [MASK_N-1:0] irq_en_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              gie_o
);

  logic [LEVELS-1:0] qual;
  logic [LEVELS-1:0] grant;
  logic              any_q;
  logic [LVL_W-1:0]  win_lvl;
  logic              gie_eff;
  logic              take;

  assign take = ack_i & req_o;

  ivc_gie_ctrl u_gie (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (gie_set_i),
    .clr_i     (gie_clr_i),
    .take_i    (take),
    .gie_o     (gie_o),
    .gie_eff_o (gie_eff)
  );

  ivc_qualify #(.LEVELS(LEVELS)) u_qual (
    .rst_req_i    (rst_req_i),
    .nmi_req_i    (nmi_req_i),
    .ofault_req_i (ofault_req_i),
    .ofault_en_i  (ofault_en_i),
    .mreq_i       (irq_req_i),
    .men_i        (irq_en_i),
    .gie_eff_i    (gie_eff),
    .qual_o       (qual)
  );

  ivc_prio_enc #(.LEVELS(LEVELS)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual_i  (qual),
    .any_o   (any_q),
    .lvl_o   (win_lvl),
    .grant_o (grant)
  );

  ivc_vec_reg #(.LEVELS(LEVELS), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .any_i (any_q),
    .lvl_i (win_lvl),
    .req_o (req_o),
    .lvl_o (level_o),
    .vec_o (vec_addr_o)
  );

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> (req_o && level_o == LVL_W'(LEVELS - 1)));             // R4
  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req_i && !rst_req_i) |=> (req_o && level_o == LVL_W'(LEVELS - 2))); // R5
  AST_MASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_o && !rst_req_i && !nmi_req_i && !(ofault_req_i && ofault_en_i))
      |=> !req_o);                                                       // R7
  AST_ACK_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o && !rst_req_i && !nmi_req_i && !(ofault_req_i && ofault_en_i))
      |=> !req_o);                                                       // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_o && !gie_set_i && !gie_clr_i) |=> gie_o == $past(gie_o)); // R10
  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (vec_addr_o == VEC_BASE + (ADDR_W'(level_o) << 1))); // R2

endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rst_req, nmi_req, of_req, of_en;
  logic [13:0] mreq, men;
  logic        gset, gclr, ack;
  logic        req_o, gie_o;
  logic [3:0]  level_o;
  logic [15:0] vec_o;

  int checks = 0;
  int fails  = 0;

  // model state
  bit m_req;
  int m_lvl;
  bit m_gie;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_req_i(nmi_req),
    .ofault_req_i(of_req), .ofault_en_i(of_en), .irq_req_i(mreq),
    .irq_en_i(men), .gie_set_i(gset), .gie_clr_i(gclr), .ack_i(ack),
    .req_o(req_o), .level_o(level_o), .vec_addr_o(vec_o), .gie_o(gie_o)
  );

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "req_o", int'(req_o), int'(m_req));
    check(tag, "level_o", int'(level_o), m_lvl);
    check(tag, "vec_addr_o", int'(vec_o), 'hFFE0 + 2 * m_lvl);
    check(tag, "gie_o", int'(gie_o), int'(m_gie));
  endtask

  task automatic idle_inputs();
    rst_req = 0; nmi_req = 0; of_req = 0; of_en = 0;
    mreq = '0; men = '0; gset = 0; gclr = 0; ack = 0;
  endtask

  // One clock: model the edge from current inputs, then compare after it.
  task automatic cycle(string tag);
    bit take, geff;
    int best;
    take = ack && m_req;
    geff = m_gie && !take;
    best = -1;
    if (rst_req) best = 15;
    else if (nmi_req || (of_req && of_en)) best = 14;
    else begin
      for (int p = 13; p >= 0; p--) begin
        if (mreq[p] && men[p] && geff) begin
          best = p;
          break;
        end
      end
    end
    if (take)      m_gie = 0;
    else if (gclr) m_gie = 0;
    else if (gset) m_gie = 1;
    m_req = (best >= 0);
    if (best >= 0) m_lvl = best;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_gie();
    idle_inputs(); gset = 1; cycle("R8");
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    m_req = 0; m_lvl = 0; m_gie = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    compare("R1");

    // R8: set, then set+clr together -> clear wins
    set_gie();
    gset = 1; gclr = 1; cycle("R8");
    idle_inputs(); cycle("R8");
    set_gie();

    // R2 / R7: each maskable level alone, enabled
    for (int p = 0; p < 14; p++) begin
      idle_inputs(); mreq[p] = 1; men[p] = 1; cycle("R2");
    end
    idle_inputs(); cycle("R11");
    cycle("R11");

    // R3: several qualify, highest enabled one wins
    mreq = 14'h0A5F; men = 14'h3FFF; cycle("R3");
    men = 14'h00FF; cycle("R3");
    mreq = 14'h2001; men = 14'h2001; cycle("R3");

    // R7: line enable off, then global enable off
    idle_inputs(); mreq = 14'h3FFF; men = 14'h0000; cycle("R7");
    idle_inputs(); gclr = 1; cycle("R7");
    idle_inputs(); mreq = 14'h3FFF; men = 14'h3FFF; cycle("R7");
    cycle("R7");

    // R5: NMI with global enable off and maskables pending
    nmi_req = 1; cycle("R5");
    nmi_req = 0; cycle("R7");

    // R6: oscillator fault gated by its enable only
    of_req = 1; of_en = 0; cycle("R6");
    of_en = 1; cycle("R6");
    of_req = 0; of_en = 0; cycle("R6");

    // R4: reset request beats everything
    set_gie();
    rst_req = 1; nmi_req = 1; of_req = 1; of_en = 1;
    mreq = 14'h3FFF; men = 14'h3FFF; cycle("R4");
    idle_inputs(); rst_req = 1; cycle("R4");
    idle_inputs(); cycle("R11");

    // R9: ack of an active maskable request blocks nesting at once
    set_gie();
    mreq[5] = 1; men[5] = 1; cycle("R9");
    mreq[9] = 1; men[9] = 1; ack = 1; gset = 1; cycle("R9");
    ack = 0; gset = 0; cycle("R9");
    cycle("R9");
    gset = 1; cycle("R9");
    gset = 0; cycle("R9");

    // R10: ack while idle leaves the enable alone
    idle_inputs(); cycle("R10");
    ack = 1; cycle("R10");
    cycle("R10");
    idle_inputs(); cycle("R10");

    // R3: random traffic against the model
    for (int n = 0; n < 400; n++) begin
      rst_req = ($urandom_range(0, 31) == 0);
      nmi_req = ($urandom_range(0, 15) == 0);
      of_req  = ($urandom_range(0, 7) == 0);
      of_en   = $urandom_range(0, 1) == 1;
      mreq    = 14'($urandom);
      men     = 14'($urandom);
      gset    = ($urandom_range(0, 3) == 0);
      gclr    = ($urandom_range(0, 7) == 0);
      ack     = ($urandom_range(0, 2) == 0);
      cycle("R3");
    end

    idle_inputs(); cycle("R11");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule